// File: doc/BRIEF.md
# SMBus Host Controller

This block is an SMBus master that a processor drives through a small byte-wide register file. Software loads the target address with its direction bit, a command byte and up to two data bytes. It then writes a start code that names the protocol. The engine runs the whole transaction on open-drain clock and data lines. When it finishes it raises exactly one sticky status flag: done, device error or collision. Bytes read from the target land in the data registers.

The protocols supported are quick command, send and receive byte, byte-data read and write, word-data read and write, and process call. Codes 5 to 7 are rejected at once. A kill bit in the host-control register aborts any transaction and returns the engine to idle. Each bit time on the bus lasts four quarter periods, and each quarter period lasts `CLK_QTR` clock cycles.

Register offsets are: status 0x0, enable 0x1, control 0x2, host control 0x3, address 0x4, command 0x5, data low 0x8 and data high 0x9.

Top module: `smbus_host_ctrl`

## Requirements
- R1: After reset every register reads 0x00. The enable register (0x1) and the address, command and data registers (0x4, 0x5, 0x8, 0x9) read back what software wrote. Unused offsets read 0x00.
- R2: A write to host control (0x3) with bit 4 set, bit 5 clear, bits [2:0] in 0..4 and the engine idle starts a transaction. Control (0x2) bits [1:0] read nonzero from the next cycle until the transaction ends, then read 00. Host control bits [2:0] read back the protocol code.
- R3: A start write while the engine is busy is ignored. The protocol code and the bus traffic stay as they were.
- R4: A host-control write with bit 5 set makes control bits [1:0] read 00 in the next cycle. Both lines are released and no status bit is set.
- R5: While idle, neither line is pulled low. A transaction lasts (bits on the bus) x 4 x `CLK_QTR` cycles, counted from the start write to the cycle in which the engine goes idle. START and STOP each count as one bit and every byte counts as nine.
- R6: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: Every transaction ends by setting exactly one status bit. Bit 3 means success. Bit 1 means a NACK, after which the engine issues STOP and sends no further bytes. Bit 2 means SDA was low while the engine released it at a START or a data bit; the engine then releases both lines without a STOP.
- R8: The address register holds the 7-bit target in bits [7:1] and the direction in bit 0 (1 = read). Quick command and send/receive byte send it unchanged. Byte-data, word-data and process-call transfers send the address with bit 0 forced to 0, and any read phase follows a repeated START with bit 0 forced to 1.
- R9: Write order is as follows. Send byte (code 1, bit 0 = 0) sends address then command. Byte-data write (code 2) sends address, command, data low. Word-data write (code 3) sends address, command, data low, data high.
- R10: Receive byte and byte-data read place the byte in data low. A word read places the first byte in data low and the second in data high. The master ACKs every read byte except the last, NACKs the last one and then issues STOP.
- R11: Process call (code 4) ignores the direction bit. It writes command, data low and data high, then repeated START, the read address, and reads two bytes into data low and data high.
- R12: A start with code 5, 6 or 7 causes no bus activity and no busy indication. It sets status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
Busy shows in the control register at the first sample after the start-write edge. The kill and unsupported-code results also appear at that same sample, so the bench reads them as soon as its write task returns. Completion is due exactly 4 x `CLK_QTR` cycles per bus bit after the start. The bench counts the falling edges on which busy is still set and compares that count with 176 for a quick command and 608 for a word write at `CLK_QTR` = 4. Status, data registers and the bus-model logs are read only after busy has cleared, because every result is final on that edge.

// File: rtl/smbus_host_ctrl.sv
module smbus_host_ctrl #(
  parameter int CLK_QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int QW = (CLK_QTR > 1) ? $clog2(CLK_QTR) : 1;
  localparam logic [3:0] A_STS = 4'h0, A_EN = 4'h1, A_CTL = 4'h2, A_HST = 4'h3,
                         A_ADR = 4'h4, A_CMD = 4'h5, A_DLO = 4'h8, A_DHI = 4'h9;
  localparam logic [3:0] O_S = 4'd0, O_SR = 4'd1, O_P = 4'd2, O_WA = 4'd3, O_WA0 = 4'd4,
                         O_WA1 = 4'd5, O_WC = 4'd6, O_WL = 4'd7, O_WH = 4'd8,
                         O_RL = 4'd9, O_RLN = 4'd10, O_RHN = 4'd11;

  logic          busy, fstop, nack;
  logic [2:0]    proto;
  logic [3:0]    step, bitn;
  logic [1:0]    ph;
  logic [QW-1:0] qcnt;
  logic [7:0]    rxs, en, adr, cmd, dlo, dhi, txb;
  logic [3:1]    sts, sts_set, sts_clr;
  logic [0:9][3:0] lst;
  logic [3:0]    op;
  logic          is_st, is_wr, is_rd, last, tick, txbit, col, fin, wr_hst, kill, go;

  assign wr_hst = reg_wr && reg_addr == A_HST;
  assign kill   = wr_hst && reg_wdata[5];
  assign go     = wr_hst && reg_wdata[4] && !reg_wdata[5] && !busy;
  assign tick   = qcnt == QW'(CLK_QTR - 1);

  always_comb begin
    case (proto)
      3'd0:    lst = {O_S, O_WA, O_P, {7{O_P}}};
      3'd1:    lst = adr[0] ? {O_S, O_WA, O_RLN, O_P, {6{O_P}}}
                            : {O_S, O_WA, O_WC, O_P, {6{O_P}}};
      3'd2:    lst = adr[0] ? {O_S, O_WA0, O_WC, O_SR, O_WA1, O_RLN, O_P, {3{O_P}}}
                            : {O_S, O_WA0, O_WC, O_WL, O_P, {5{O_P}}};
      3'd3:    lst = adr[0] ? {O_S, O_WA0, O_WC, O_SR, O_WA1, O_RL, O_RHN, O_P, {2{O_P}}}
                            : {O_S, O_WA0, O_WC, O_WL, O_WH, O_P, {4{O_P}}};
      default: lst = {O_S, O_WA0, O_WC, O_WL, O_WH, O_SR, O_WA1, O_RL, O_RHN, O_P};
    endcase
    op = fstop ? O_P : lst[step];
    case (op)
      O_WA:    txb = adr;
      O_WA0:   txb = {adr[7:1], 1'b0};
      O_WA1:   txb = {adr[7:1], 1'b1};
      O_WC:    txb = cmd;
      O_WL:    txb = dlo;
      O_WH:    txb = dhi;
      default: txb = 8'h00;
    endcase
  end

  assign is_st = op == O_S || op == O_SR;
  assign is_wr = op >= O_WA && op <= O_WH;
  assign is_rd = op >= O_RL;
  assign last  = op == O_RLN || op == O_RHN;
  assign txbit = txb[3'd7 - bitn[2:0]];

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    if (busy) begin
      if (is_st) begin
        scl_oe = ph == 2'd3 || (op == O_SR && ph == 2'd0);
        sda_oe = ph[1];
      end else if (op == O_P) begin
        scl_oe = ph == 2'd0;
        sda_oe = ph != 2'd3;
      end else begin
        scl_oe = ph == 2'd0 || ph == 2'd3;
        if (is_wr) sda_oe = bitn < 4'd8 && !txbit;
        else       sda_oe = bitn == 4'd8 && !last;
      end
    end
  end

  assign col = busy && tick && ph == 2'd1 && !sda_in &&
               (is_st || (is_wr && bitn < 4'd8 && txbit));
  assign fin = busy && tick && ph == 2'd3 && op == O_P;
  assign sts_set = {fin && !nack, col, (fin && nack) || (go && reg_wdata[2:0] > 3'd4)};
  assign sts_clr = (reg_wr && reg_addr == A_STS) ? reg_wdata[3:1] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; fstop <= 1'b0; nack <= 1'b0; proto <= '0; step <= '0; bitn <= '0;
      ph <= '0; qcnt <= '0; rxs <= '0; en <= '0; adr <= '0; cmd <= '0; dlo <= '0;
      dhi <= '0; sts <= '0;
    end else begin
      sts <= (sts & ~sts_clr) | sts_set;
      if (reg_wr) begin
        case (reg_addr)
          A_EN:  en  <= reg_wdata;
          A_ADR: adr <= reg_wdata;
          A_CMD: cmd <= reg_wdata;
          A_DLO: dlo <= reg_wdata;
          A_DHI: dhi <= reg_wdata;
          default: ;
        endcase
      end
      if (kill) begin
        busy <= 1'b0;
      end else if (go) begin
        busy  <= reg_wdata[2:0] <= 3'd4;
        proto <= reg_wdata[2:0];
        step <= '0; bitn <= '0; ph <= '0; qcnt <= '0; fstop <= 1'b0; nack <= 1'b0;
      end else if (busy) begin
        qcnt <= tick ? '0 : qcnt + 1'b1;
        if (tick) ph <= ph + 2'd1;
        if (col) begin
          busy <= 1'b0;
        end else if (tick && ph == 2'd1) begin
          if (is_wr && bitn == 4'd8) nack <= sda_in;
          if (is_rd && bitn < 4'd8)  rxs <= {rxs[6:0], sda_in};
        end else if (tick && ph == 2'd3) begin
          if (op == O_P) begin
            busy <= 1'b0;
          end else if (is_st) begin
            step <= step + 4'd1;
          end else if (bitn == 4'd8) begin
            bitn <= '0;
            if (is_wr && nack) fstop <= 1'b1;
            else               step  <= step + 4'd1;
            if (op == O_RL || op == O_RLN) dlo <= rxs;
            if (op == O_RHN)               dhi <= rxs;
          end else begin
            bitn <= bitn + 4'd1;
          end
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = {4'b0, sts, 1'b0};
      A_EN:    reg_rdata = en;
      A_CTL:   reg_rdata = {6'b0, busy && fstop, busy};
      A_HST:   reg_rdata = {5'b0, proto};
      A_ADR:   reg_rdata = adr;
      A_CMD:   reg_rdata = cmd;
      A_DLO:   reg_rdata = dlo;
      A_DHI:   reg_rdata = dhi;
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/smbus_host_ctrl_chk.sv
module smbus_host_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic [2:0] proto,
  input logic [3:1] sts
);
  a_r5_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  a_r4_kill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'h3 && reg_wdata[5]) |=> !busy);

  a_r3_busy_start_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 4'h3 && !reg_wdata[5]) |=> $stable(proto));

  a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'h0 && !busy) |=> ((sts & $past(reg_wdata[3:1])) == 3'b000));

  a_r7_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(reg_wr && reg_addr == 4'h3) && !$past(reg_wr && reg_addr == 4'h0))
      |-> (sts != 3'b000));
endmodule

bind smbus_host_ctrl smbus_host_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .proto(proto), .sts(sts)
);

// File: tb/smbus_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module smbus_host_ctrl_tb_top;
  localparam int QTR = 4;
  localparam logic [6:0] TGT = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, scl_oe, sda_oe, slv_lo = 1'b0, jam = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl, sda;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  assign scl = !scl_oe;
  assign sda = !(sda_oe || slv_lo || jam);

  always #4 clk = !clk;

  smbus_host_ctrl #(.CLK_QTR(QTR)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda));

  logic [7:0] rx_log [0:15];
  logic [7:0] txq [0:3];
  bit mack_log [0:7];
  int ln = 0, mack_n = 0, ti = 0, bc = 0, tc = 0;
  bit ps = 1, pd = 1, active = 0, rxa = 0, txm = 0, sel = 0, rdir = 0;
  logic [7:0] sh = '0;

  always @(negedge clk) begin
    logic s, d;
    s = scl; d = sda;
    if (ps && s && pd && !d) begin
      bc = 0; rxa = 1; txm = 0; slv_lo = 0; active = 1;
    end else if (ps && s && !pd && d) begin
      active = 0; txm = 0; slv_lo = 0;
    end else if (active) begin
      if (!ps && s) begin
        if (!txm && bc < 8) begin sh = {sh[6:0], d}; bc++; end
        else if (txm && tc == 8) begin mack_log[mack_n] = !d; mack_n++; end
      end else if (ps && !s) begin
        if (!txm) begin
          if (bc == 8) begin
            rx_log[ln] = sh; ln++;
            sel = rxa ? (sh[7:1] == TGT) : 1'b1;
            rdir = rxa && sh[0];
            slv_lo = sel; bc = 9;
          end else if (bc == 9) begin
            slv_lo = 0; bc = 0; rxa = 0;
            if (!sel) active = 0;
            else if (rdir) begin txm = 1; tc = 0; slv_lo = !txq[ti][7]; end
          end
        end else begin
          tc++;
          if (tc < 8) slv_lo = !txq[ti][7 - tc];
          else if (tc == 8) slv_lo = 0;
          else if (mack_log[mack_n - 1]) begin ti++; tc = 0; slv_lo = !txq[ti][7]; end
          else begin txm = 0; active = 0; slv_lo = 0; end
        end
      end
    end
    ps = s; pd = d;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic clear_log();
    ln = 0; mack_n = 0; ti = 0;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] v;
    n = 0; rd(4'h2, v);
    while (v[1:0] != 2'b00 && n < 5000) begin @(negedge clk); n++; rd(4'h2, v); end
    if (n >= 5000) chk("R2 busy never cleared", n, 0);
  endtask

  task automatic run(input logic [2:0] code, output int n);
    logic [7:0] v;
    clear_log();
    wr(4'h3, {5'b00010, code});
    rd(4'h2, v); chk("R2 busy after start", int'(v[1:0] != 0), 1);
    wait_idle(n);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 16; a++) begin rd(a[3:0], v); chk("R1 reset value", v, 0); end
    chk("R5 idle lines", {scl_oe, sda_oe}, 0);
    wr(4'h1, 8'h5A); rd(4'h1, v); chk("R1 enable readback", v, 8'h5A);
    wr(4'h6, 8'hFF); rd(4'h6, v); chk("R1 unused offset", v, 0);
  endtask

  task automatic t_quick();
    logic [7:0] v; int n;
    wr(4'h4, {TGT, 1'b0}); run(3'd0, n);
    chk("R5 quick duration", n, 44 * QTR);
    rd(4'h0, v); chk("R7 quick done", v, 8'h08);
    chk("R8 quick bytes", ln, 1); chk("R8 quick addr", rx_log[0], {TGT, 1'b0});
    rd(4'h3, v); chk("R2 code readback", v, 0);
    wr(4'h0, 8'h06); rd(4'h0, v); chk("R6 zero-bit write keeps", v, 8'h08);
    wr(4'h0, 8'h08); rd(4'h0, v); chk("R6 w1c clears", v, 0);
  endtask

  task automatic t_send_byte();
    logic [7:0] v; int n;
    wr(4'h4, {TGT, 1'b0}); wr(4'h5, 8'h9C); run(3'd1, n);
    chk("R9 send count", ln, 2); chk("R9 send cmd", rx_log[1], 8'h9C);
    rd(4'h0, v); chk("R7 send done", v, 8'h08); wr(4'h0, 8'h0E);
  endtask

  task automatic t_recv_byte();
    logic [7:0] v; int n;
    txq[0] = 8'hA5; wr(4'h4, {TGT, 1'b1}); run(3'd1, n);
    rd(4'h8, v); chk("R10 recv byte dlo", v, 8'hA5);
    chk("R8 recv addr", rx_log[0], {TGT, 1'b1});
    chk("R10 recv nack last", mack_n == 1 && !mack_log[0], 1);
    rd(4'h0, v); chk("R7 recv done", v, 8'h08); wr(4'h0, 8'h0E);
  endtask

  task automatic t_bdata();
    logic [7:0] v; int n;
    wr(4'h4, {TGT, 1'b0}); wr(4'h5, 8'h31); wr(4'h8, 8'hC7); run(3'd2, n);
    chk("R9 bdata count", ln, 3);
    chk("R9 bdata order", {rx_log[0], rx_log[1], rx_log[2]}, {TGT, 1'b0, 8'h31, 8'hC7});
    txq[0] = 8'h3E; wr(4'h4, {TGT, 1'b1}); run(3'd2, n);
    chk("R8 bdata read frame", {rx_log[0], rx_log[1], rx_log[2]}, {TGT, 1'b0, 8'h31, TGT, 1'b1});
    rd(4'h8, v); chk("R10 bdata read dlo", v, 8'h3E);
    wr(4'h0, 8'h0E);
  endtask

  task automatic t_word();
    logic [7:0] v; int n;
    wr(4'h4, {TGT, 1'b0}); wr(4'h5, 8'h44); wr(4'h8, 8'h12); wr(4'h9, 8'h34); run(3'd3, n);
    chk("R5 word duration", n, 152 * QTR);
    chk("R9 word order", {rx_log[1], rx_log[2], rx_log[3]}, {8'h44, 8'h12, 8'h34});
    txq[0] = 8'h9A; txq[1] = 8'hBC; wr(4'h4, {TGT, 1'b1}); run(3'd3, n);
    rd(4'h8, v); chk("R10 word lo", v, 8'h9A);
    rd(4'h9, v); chk("R10 word hi", v, 8'hBC);
    chk("R10 word ack then nack", {mack_n[1:0], mack_log[0], mack_log[1]}, {2'd2, 1'b1, 1'b0});
    rd(4'h0, v); chk("R7 word done", v, 8'h08); wr(4'h0, 8'h0E);
  endtask

  task automatic t_pcall();
    logic [7:0] v; int n;
    wr(4'h4, {TGT, 1'b1}); wr(4'h5, 8'h77); wr(4'h8, 8'h01); wr(4'h9, 8'h02);
    txq[0] = 8'hD1; txq[1] = 8'hE2; run(3'd4, n);
    chk("R11 pcall count", ln, 5);
    chk("R11 pcall frame", {rx_log[0], rx_log[1], rx_log[2], rx_log[3], rx_log[4]},
        {TGT, 1'b0, 8'h77, 8'h01, 8'h02, TGT, 1'b1});
    rd(4'h8, v); chk("R11 pcall lo", v, 8'hD1);
    rd(4'h9, v); chk("R11 pcall hi", v, 8'hE2);
    wr(4'h0, 8'h0E);
  endtask

  task automatic t_nack();
    logic [7:0] v; int n;
    wr(4'h4, {7'h33, 1'b0}); wr(4'h5, 8'h55); run(3'd2, n);
    rd(4'h0, v); chk("R7 nack flag only", v, 8'h02);
    chk("R7 nack no more bytes", ln, 1);
    chk("R7 nack lines released", {scl_oe, sda_oe, sda}, 3'b001);
    wr(4'h0, 8'h02);
  endtask

  task automatic t_collision();
    logic [7:0] v; int n;
    jam = 1'b1; wr(4'h4, {TGT, 1'b0}); run(3'd0, n); jam = 1'b0;
    rd(4'h0, v); chk("R7 collision flag", v, 8'h04);
    chk("R7 collision released", {scl_oe, sda_oe}, 0);
    wr(4'h0, 8'h04);
  endtask

  task automatic t_kill();
    logic [7:0] v;
    clear_log(); wr(4'h4, {TGT, 1'b0}); wr(4'h3, 8'h13);
    repeat (100) @(negedge clk);
    wr(4'h3, 8'h20);
    rd(4'h2, v); chk("R4 kill idle", v[1:0], 0);
    chk("R4 kill lines", {scl_oe, sda_oe}, 0);
    repeat (40) @(negedge clk);
    rd(4'h0, v); chk("R4 kill no status", v, 0);
  endtask

  task automatic t_busy_start();
    logic [7:0] v; int n;
    clear_log(); wr(4'h4, {TGT, 1'b0}); wr(4'h3, 8'h10);
    repeat (20) @(negedge clk);
    wr(4'h3, 8'h13);
    rd(4'h3, v); chk("R3 code kept", v, 0);
    wait_idle(n);
    chk("R3 traffic unchanged", ln, 1);
    rd(4'h0, v); chk("R3 done", v, 8'h08); wr(4'h0, 8'h08);
  endtask

  task automatic t_unsupported();
    logic [7:0] v;
    clear_log(); wr(4'h3, 8'h15);
    rd(4'h2, v); chk("R12 no busy", v[1:0], 0);
    rd(4'h0, v); chk("R12 error flag", v, 8'h02);
    repeat (200) @(negedge clk);
    chk("R12 no traffic", ln, 0);
    chk("R12 lines idle", {scl_oe, sda_oe}, 0);
    wr(4'h0, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_quick();
    t_send_byte();
    t_recv_byte();
    t_bdata();
    t_word();
    t_pcall();
    t_nack();
    t_collision();
    t_kill();
    t_busy_start();
    t_unsupported();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule